// File: doc/BRIEF.md
# Word-Line and Column Repair Steering

This block sits between the address and data paths of an SRAM sub-array and its word lines and bit-line columns. It allows a manufactured array with a few bad rows and columns to behave as a defect-free one. Every row access is compared in a single cycle against a small table of repair entries. Each entry holds a row address and an enable flag. When an enabled entry matches, the access goes to that entry's spare word line, and the normal one-hot row decode is held off. When no entry matches, the normal decoded line fires.

On the data side, a column mask marks the physical columns that are defective. Write data is spread across the physical columns so that it skips each marked column and spills onto the spare columns at the top. Read data goes through the inverse mapping, so the bits come back in logical order. The mask and the repair table are loaded through a configuration port while a configuration mode input is high. That port stands in for fuses, and the values persist after configuration mode ends.

Word-line outputs are registered, so they appear one clock after the address is sampled. Column steering is purely combinational.

Top module: `mem_repair_steer`

## Requirements
- R1: After synchronous reset, all word lines are low, every repair entry is disabled and the column mask is empty. In this state row decode and column steering are the identity mapping.
- R2: Take a rising edge where acc_en is high, cfg_mode is low and no enabled entry matches. After that edge, wl_norm has exactly bit row_addr set and wl_spare is zero.
- R3: Take a rising edge where an enabled entry i holds a row address equal to row_addr, with acc_en high and cfg_mode low. After that edge, wl_spare[i] is high and all of wl_norm is low.
- R4: An entry whose enable flag is clear never matches, even when its stored address equals row_addr.
- R5: When several enabled entries match, only the lowest-numbered one drives its wl_spare bit. At most one wl_spare bit is ever high.
- R6: Take a rising edge where acc_en is low or cfg_mode is high. After that edge, every word line is low.
- R7: Entry cfg_row_idx takes cfg_row_addr and cfg_row_en only on a rising edge where cfg_mode and cfg_row_we are both high. A write attempt with cfg_mode low changes nothing, and stored entries keep their values after cfg_mode falls.
- R8: cfg_col_mask bit p set marks physical column p as faulty. The mask loads on a rising edge where cfg_mode and cfg_col_we are both high. A mask with more than 2 bits set is refused, and the previous mask stays in force.
- R9: Write steering: walk the physical columns from 0 upward, skipping the faulty ones. Logical bit k lands on the k-th healthy column. Faulty columns and healthy columns left unused are driven 0. With an empty mask, phy_wr equals wr_data with two zero spare bits on top.
- R10: Read steering is the inverse of R9. rd_data[k] is taken from the k-th healthy physical column, so a write that is read back returns the original data.
- R11: Column steering is combinational. phy_wr and rd_data follow wr_data and phy_rd without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 1 | Configuration mode. Enables table and mask writes and blocks accesses |
| cfg_row_we | input | 1 | Write strobe for one repair entry |
| cfg_row_idx | input | 2 | Index of the repair entry to write |
| cfg_row_addr | input | 7 | Row address to store in the entry |
| cfg_row_en | input | 1 | Enable flag to store in the entry |
| cfg_col_we | input | 1 | Write strobe for the column mask |
| cfg_col_mask | input | 10 | Faulty-column mask, one bit per physical column |
| acc_en | input | 1 | Access enable |
| row_addr | input | 7 | Row address of the access |
| wl_norm | output | 128 | Normal word lines, registered |
| wl_spare | output | 4 | Spare word lines, registered |
| wr_data | input | 8 | Logical write data |
| phy_wr | output | 10 | Write data steered onto the physical columns |
| phy_rd | input | 10 | Read data from the physical columns |
| rd_data | output | 8 | Read data restored to logical order |

## Verification
Row decode is exercised with addresses at both ends and in the middle of the range, with no entries set. This separates a correct one-hot decode from a stuck or shifted decode. Four cases then separate matching, enabling and priority from each other: an enabled entry at a chosen address, a disabled entry at the same address, two enabled entries on one address, and a miss just beside a programmed address. Column steering is checked against independently computed mappings for several masks. The masks cover an empty mask, one faulty column at the bottom, two adjacent faulty columns, two faulty columns far apart, and a refused three-bit mask. Together they distinguish a correct skip count from an off-by-one shift, and a correct refusal from a silent reload.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  localparam int ROW_AW_DEF      = 7;
  localparam int SPARE_ROWS_DEF  = 4;
  localparam int DATA_W_DEF      = 8;
  localparam int SPARE_COLS_DEF  = 2;

  function automatic int ones32(input logic [31:0] v);
    int n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/mrs_row_repair.sv
module mrs_row_repair #(
  parameter int ROW_AW = 7,
  parameter int NSPARE = 4,
  localparam int IDX_W = (NSPARE > 1) ? $clog2(NSPARE) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ok,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ROW_AW-1:0] wr_addr,
  input  logic              wr_en_flag,
  input  logic [ROW_AW-1:0] row_addr,
  output logic              hit,
  output logic [NSPARE-1:0] hit_vec
);
  logic [ROW_AW-1:0] tag_q [NSPARE];
  logic [NSPARE-1:0] vld_q;
  logic [NSPARE-1:0] raw_match;

  for (genvar g = 0; g < NSPARE; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        tag_q[g] <= '0;
        vld_q[g] <= 1'b0;
      end else if (wr_ok && (wr_idx == IDX_W'(g))) begin
        tag_q[g] <= wr_addr;
        vld_q[g] <= wr_en_flag;
      end
    end

    assign raw_match[g] = vld_q[g] && (tag_q[g] == row_addr);

    // R7: entry unchanged unless addressed by a permitted write
    p_entry_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !(wr_ok && (wr_idx == IDX_W'(g))) |=> ($stable(tag_q[g]) && $stable(vld_q[g])));
  end

  // lowest index wins
  always_comb begin
    hit_vec = '0;
    for (int i = NSPARE - 1; i >= 0; i--) begin
      if (raw_match[i]) begin
        hit_vec    = '0;
        hit_vec[i] = 1'b1;
      end
    end
  end

  assign hit = |raw_match;

  // R5: priority result never names more than one entry
  p_prio_single_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec) && (hit == (|hit_vec)));
endmodule

// File: rtl/mrs_wl_driver.sv
module mrs_wl_driver #(
  parameter int ROW_AW = 7,
  parameter int NSPARE = 4,
  localparam int NROWS = 1 << ROW_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [ROW_AW-1:0] row_addr,
  input  logic              hit,
  input  logic [NSPARE-1:0] hit_vec,
  output logic [NROWS-1:0]  wl_norm,
  output logic [NSPARE-1:0] wl_spare
);
  logic [NROWS-1:0] dec_d;

  always_comb begin
    dec_d = '0;
    dec_d[row_addr] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wl_norm  <= '0;
      wl_spare <= '0;
    end else begin
      wl_norm  <= (fire && !hit) ? dec_d : '0;
      wl_spare <= fire ? hit_vec : '0;
    end
  end

  // R5: never more than one spare line
  p_spare_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wl_spare));

  // R3: spare selection suppresses every normal line
  p_spare_excl_r3: assert property (@(posedge clk) disable iff (rst)
    (|wl_spare) |-> (wl_norm == '0));

  // R6: idle access leaves everything low
  p_idle_low_r6: assert property (@(posedge clk) disable iff (rst)
    !fire |=> ((wl_norm == '0) && (wl_spare == '0)));

  // R2: unmatched access fires exactly the addressed line
  p_norm_single_r2: assert property (@(posedge clk) disable iff (rst)
    (fire && !hit) |=> (($countones(wl_norm) == 1) && wl_norm[$past(row_addr)]));
endmodule

// File: rtl/mrs_col_shift.sv
module mrs_col_shift #(
  parameter int DATA_W = 8,
  parameter int NSPARE = 2,
  localparam int PHY_W = DATA_W + NSPARE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ok,
  input  logic [PHY_W-1:0]  new_mask,
  input  logic [DATA_W-1:0] wr_data,
  output logic [PHY_W-1:0]  phy_wr,
  input  logic [PHY_W-1:0]  phy_rd,
  output logic [DATA_W-1:0] rd_data
);
  logic [PHY_W-1:0] mask_q;
  logic             mask_fits;
  int               lg;

  always_comb begin
    int n;
    n = 0;
    for (int p = 0; p < PHY_W; p++) n += int'(new_mask[p]);
    mask_fits = (n <= NSPARE);
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else if (wr_ok && mask_fits) mask_q <= new_mask;
  end

  always_comb begin
    phy_wr  = '0;
    rd_data = '0;
    lg      = 0;
    for (int p = 0; p < PHY_W; p++) begin
      if (!mask_q[p]) begin
        if (lg < DATA_W) begin
          phy_wr[p]   = wr_data[lg];
          rd_data[lg] = phy_rd[p];
        end
        lg = lg + 1;
      end
    end
  end

  // R8: stored mask never exceeds the spare count
  p_mask_limit_r8: assert property (@(posedge clk) disable iff (rst)
    $countones(mask_q) <= NSPARE);

  // R9: a faulty column is never driven
  p_faulty_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (phy_wr & mask_q) == '0);
endmodule

// File: rtl/mem_repair_steer.sv
module mem_repair_steer
  import mrs_pkg::*;
#(
  parameter int ROW_AW     = ROW_AW_DEF,
  parameter int SPARE_ROWS = SPARE_ROWS_DEF,
  parameter int DATA_W     = DATA_W_DEF,
  parameter int SPARE_COLS = SPARE_COLS_DEF,
  localparam int NROWS     = 1 << ROW_AW,
  localparam int PHY_W     = DATA_W + SPARE_COLS,
  localparam int IDX_W     = (SPARE_ROWS > 1) ? $clog2(SPARE_ROWS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_mode,
  input  logic              cfg_row_we,
  input  logic [IDX_W-1:0]  cfg_row_idx,
  input  logic [ROW_AW-1:0] cfg_row_addr,
  input  logic              cfg_row_en,
  input  logic              cfg_col_we,
  input  logic [PHY_W-1:0]  cfg_col_mask,
  input  logic              acc_en,
  input  logic [ROW_AW-1:0] row_addr,
  output logic [NROWS-1:0]  wl_norm,
  output logic [SPARE_ROWS-1:0] wl_spare,
  input  logic [DATA_W-1:0] wr_data,
  output logic [PHY_W-1:0]  phy_wr,
  input  logic [PHY_W-1:0]  phy_rd,
  output logic [DATA_W-1:0] rd_data
);
  logic                  fire;
  logic                  hit;
  logic [SPARE_ROWS-1:0] hit_vec;

  assign fire = acc_en && !cfg_mode;

  mrs_row_repair #(.ROW_AW(ROW_AW), .NSPARE(SPARE_ROWS)) u_rows (
    .clk(clk), .rst(rst),
    .wr_ok(cfg_mode && cfg_row_we),
    .wr_idx(cfg_row_idx), .wr_addr(cfg_row_addr), .wr_en_flag(cfg_row_en),
    .row_addr(row_addr), .hit(hit), .hit_vec(hit_vec)
  );

  mrs_wl_driver #(.ROW_AW(ROW_AW), .NSPARE(SPARE_ROWS)) u_wl (
    .clk(clk), .rst(rst), .fire(fire), .row_addr(row_addr),
    .hit(hit), .hit_vec(hit_vec), .wl_norm(wl_norm), .wl_spare(wl_spare)
  );

  mrs_col_shift #(.DATA_W(DATA_W), .NSPARE(SPARE_COLS)) u_cols (
    .clk(clk), .rst(rst), .wr_ok(cfg_mode && cfg_col_we),
    .new_mask(cfg_col_mask), .wr_data(wr_data), .phy_wr(phy_wr),
    .phy_rd(phy_rd), .rd_data(rd_data)
  );
endmodule

// File: tb/mem_repair_steer_test.sv
module mem_repair_steer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_mode = 0, cfg_row_we = 0, cfg_row_en = 0, cfg_col_we = 0, acc_en = 0;
  logic [1:0] cfg_row_idx = '0;
  logic [6:0] cfg_row_addr = '0, row_addr = '0;
  logic [9:0] cfg_col_mask = '0, phy_rd = '0, phy_wr;
  logic [7:0] wr_data = '0, rd_data;
  logic [127:0] wl_norm;
  logic [3:0] wl_spare;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mem_repair_steer uut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_row_we(cfg_row_we),
    .cfg_row_idx(cfg_row_idx), .cfg_row_addr(cfg_row_addr), .cfg_row_en(cfg_row_en),
    .cfg_col_we(cfg_col_we), .cfg_col_mask(cfg_col_mask), .acc_en(acc_en),
    .row_addr(row_addr), .wl_norm(wl_norm), .wl_spare(wl_spare),
    .wr_data(wr_data), .phy_wr(phy_wr), .phy_rd(phy_rd), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [131:0] act, input logic [131:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] one_row(input logic [6:0] a);
    logic [127:0] v;
    v = '0;
    v[a] = 1'b1;
    return v;
  endfunction

  // model of R9: k-th healthy column carries logical bit k
  function automatic logic [9:0] model_wr(input logic [9:0] m, input logic [7:0] d);
    logic [9:0] v;
    int k;
    v = '0;
    k = 0;
    for (int p = 0; p < 10; p++)
      if (!m[p]) begin
        if (k < 8) v[p] = d[k];
        k++;
      end
    return v;
  endfunction

  function automatic logic [7:0] model_rd(input logic [9:0] m, input logic [9:0] ph);
    logic [7:0] v;
    int k;
    v = '0;
    k = 0;
    for (int p = 0; p < 10; p++)
      if (!m[p]) begin
        if (k < 8) v[k] = ph[p];
        k++;
      end
    return v;
  endfunction

  task automatic access(input logic [6:0] a, input logic en);
    @(negedge clk);
    row_addr = a;
    acc_en = en;
    @(posedge clk);
    #1;
  endtask

  task automatic wr_entry(input logic [1:0] i, input logic [6:0] a, input logic en, input logic mode);
    @(negedge clk);
    acc_en = 0;
    cfg_mode = mode;
    cfg_row_we = 1;
    cfg_row_idx = i;
    cfg_row_addr = a;
    cfg_row_en = en;
    @(negedge clk);
    cfg_row_we = 0;
    cfg_mode = 0;
  endtask

  task automatic wr_mask(input logic [9:0] m);
    @(negedge clk);
    cfg_mode = 1;
    cfg_col_we = 1;
    cfg_col_mask = m;
    @(negedge clk);
    cfg_col_we = 0;
    cfg_mode = 0;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic t_reset;
    do_reset();
    chk("R1 wl_norm after reset", {4'b0, wl_norm}, '0);
    chk("R1 wl_spare after reset", {128'b0, wl_spare}, '0);
    wr_data = 8'hA5;
    #1;
    chk("R1 identity column map", {122'b0, phy_wr}, {124'b0, 8'hA5});
  endtask

  task automatic t_decode;
    logic [6:0] pats [4] = '{7'd0, 7'd127, 7'd64, 7'd37};
    foreach (pats[i]) begin
      access(pats[i], 1'b1);
      chk("R2 normal one-hot", {wl_spare, wl_norm}, {4'b0, one_row(pats[i])});
    end
  endtask

  task automatic t_spare;
    wr_entry(2'd2, 7'd50, 1'b1, 1'b1);
    access(7'd50, 1'b1);
    chk("R3 spare 2 selected", {wl_spare, wl_norm}, {4'b0100, 128'b0});
    access(7'd51, 1'b1);
    chk("R3 neighbour misses", {wl_spare, wl_norm}, {4'b0, one_row(7'd51)});
  endtask

  task automatic t_disabled;
    wr_entry(2'd2, 7'd50, 1'b0, 1'b1);
    access(7'd50, 1'b1);
    chk("R4 disabled entry ignored", {wl_spare, wl_norm}, {4'b0, one_row(7'd50)});
  endtask

  task automatic t_priority;
    wr_entry(2'd3, 7'd9, 1'b1, 1'b1);
    wr_entry(2'd1, 7'd9, 1'b1, 1'b1);
    access(7'd9, 1'b1);
    chk("R5 lowest entry wins", {wl_spare, wl_norm}, {4'b0010, 128'b0});
  endtask

  task automatic t_gate;
    access(7'd9, 1'b0);
    chk("R6 acc_en low", {wl_spare, wl_norm}, '0);
    @(negedge clk);
    cfg_mode = 1;
    access(7'd20, 1'b1);
    chk("R6 cfg_mode high", {wl_spare, wl_norm}, '0);
    @(negedge clk);
    cfg_mode = 0;
  endtask

  task automatic t_cfg_guard;
    wr_entry(2'd0, 7'd77, 1'b1, 1'b0);
    access(7'd77, 1'b1);
    chk("R7 write without cfg_mode ignored", {wl_spare, wl_norm}, {4'b0, one_row(7'd77)});
    access(7'd9, 1'b1);
    chk("R7 earlier entry held", {wl_spare, wl_norm}, {4'b0010, 128'b0});
  endtask

  task automatic t_cols;
    logic [9:0] masks [4] = '{10'b00_0000_0001, 10'b00_0011_0000, 10'b10_0000_0010, 10'b00_0000_0000};
    foreach (masks[i]) begin
      wr_mask(masks[i]);
      wr_data = 8'h5C ^ 8'(i * 37);
      phy_rd = 10'h2B7 ^ 10'(i * 91);
      #1;
      chk("R9 write steering", {122'b0, phy_wr}, {122'b0, model_wr(masks[i], wr_data)});
      chk("R10 read steering", {124'b0, rd_data}, {124'b0, model_rd(masks[i], phy_rd)});
      phy_rd = phy_wr;
      #1;
      chk("R10 round trip", {124'b0, rd_data}, {124'b0, wr_data});
    end
    wr_mask(10'b00_0100_1000);
    wr_mask(10'b11_1000_0000);
    wr_data = 8'hFF;
    #1;
    chk("R8 three-bit mask refused", {122'b0, phy_wr}, {122'b0, model_wr(10'b00_0100_1000, 8'hFF)});
    wr_data = 8'h01;
    #1;
    chk("R11 combinational follow", {122'b0, phy_wr}, {122'b0, model_wr(10'b00_0100_1000, 8'h01)});
  endtask

  initial begin
    t_reset();
    t_decode();
    t_spare();
    t_disabled();
    t_priority();
    t_gate();
    t_cfg_guard();
    t_cols();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule